// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Bypass

This block sits between a set of level-sensitive interrupt sources and a parent interrupt controller. It collects up to 32 source lines. Each line is qualified by a software-visible enable bit. The qualified lines reach the parent in one of two ways. Most lines are merged into a small number of aggregated request outputs. Each of those outputs has its own selection mask, fixed at elaboration. A few selected lines, typically serial-port sources, skip the merge and drive a dedicated output of their own.

Software reaches the block through a narrow valid/ready register port. The enable word sits at byte offset 0x0. A read-only pending word at byte offset 0x4 shows which enabled sources are active. Sources are level-triggered, so no acknowledge write exists: a pending bit falls as soon as its source line drops.

For power management, a suspend pulse captures the enable word merged with the bypass set. When the block is built wake-capable, that pulse also opens the caller's wake sources. A resume pulse restores the captured word.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the enable word reads back as the bypass mask restricted to wired positions, and the pending word reads zero when no source is active.
- R2: A write to byte offset 0x0 sets the enable word to the written data restricted to wired positions. Unwired positions always read back as zero.
- R3: A read of byte offset 0x4 returns source AND enable AND wired-mask.
- R4: Writes to offset 0x4 or to any offset other than 0x0 leave the enable word unchanged. Reads of offsets other than 0x0 and 0x4 return zero.
- R5: Aggregated output k is high exactly when some wired, non-bypassed source selected by map mask k is both active and enabled.
- R6: Fast-path output bit i equals source i AND enable i for wired bypassed positions. Every other bit is zero, and a bypassed source never raises an aggregated output.
- R7: A suspend pulse stores (enable OR bypass mask) as the saved word. When the block is wake-capable, the enable word becomes the saved word OR the wired wake-active bits.
- R8: A resume pulse writes the saved word back into the enable word.
- R9: Every accepted request produces a response strobe exactly one cycle later, carrying the read data. The port is always ready.
- R10: When suspend and a bus write to offset 0x0 occur in the same cycle, suspend decides the new enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC | Level-sensitive source lines |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Byte address |
| req_wdata_i | input | NUM_SRC | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | NUM_SRC | Read data |
| suspend_i | input | 1 | Suspend capture pulse |
| resume_i | input | 1 | Resume restore pulse |
| wake_active_i | input | NUM_SRC | Sources allowed to wake during suspend |
| agg_irq_o | output | NUM_AGG | Aggregated requests to the parent |
| fwd_irq_o | output | NUM_SRC | Fast-path requests for bypassed sources |

## Verification
The hardest situation to reach from the ports is the suspend capture while software is writing the enable word in the same cycle. It needs a bus write and a suspend pulse driven on one edge, followed by a readback that shows the suspend result won. The stimulus first places a known enable value and raises wake sources on both wired and unwired positions. It then issues a suspend alone, followed by a collision between suspend and a write, and finally a resume. Each step is followed by a readback of the enable word, so that the saved word, the wake merge and the restore can be seen without looking inside the block.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    localparam int unsigned SRC_W  = 32;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PENDING = 3'd4;

    typedef struct packed {
        logic [SRC_W-1:0] en;
        logic [SRC_W-1:0] saved;
        logic             rsp_valid;
        logic [SRC_W-1:0] rdata;
    } regs_state_t;
endpackage

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
    import irq_cascade_pkg::*;
#(
    parameter logic [SRC_W-1:0] WIRED_MASK   = 32'h0000_0FFF,
    parameter logic [SRC_W-1:0] BYPASS_MASK  = 32'h0000_0007,
    parameter bit               WAKE_CAPABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [SRC_W-1:0]  req_wdata_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic [SRC_W-1:0]  wake_active_i,
    input  logic [SRC_W-1:0]  pending_i,
    output logic [SRC_W-1:0]  en_o,
    output logic              rsp_valid_o,
    output logic [SRC_W-1:0]  rsp_rdata_o
);
    localparam logic [SRC_W-1:0] RESET_EN = BYPASS_MASK & WIRED_MASK;

    regs_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid_i;
        st_d.rdata     = '0;
        if (req_valid_i && !req_write_i) begin
            if (req_addr_i == OFS_ENABLE)       st_d.rdata = st_q.en;
            else if (req_addr_i == OFS_PENDING) st_d.rdata = pending_i;
        end
        if (suspend_i) begin
            st_d.saved = (st_q.en | BYPASS_MASK) & WIRED_MASK;
            if (WAKE_CAPABLE)
                st_d.en = ((st_q.en | BYPASS_MASK) | wake_active_i) & WIRED_MASK;
        end else if (resume_i) begin
            st_d.en = st_q.saved;
        end else if (req_valid_i && req_write_i && req_addr_i == OFS_ENABLE) begin
            st_d.en = req_wdata_i & WIRED_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en        <= RESET_EN;
            st_q.saved     <= RESET_EN;
            st_q.rsp_valid <= 1'b0;
            st_q.rdata     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o        = st_q.en;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rdata;
endmodule

// File: rtl/irq_cascade_route.sv
module irq_cascade_route
    import irq_cascade_pkg::*;
#(
    parameter int unsigned NUM_AGG = 2,
    parameter logic [NUM_AGG-1:0][SRC_W-1:0] AGG_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [SRC_W-1:0] WIRED_MASK  = 32'h0000_0FFF,
    parameter logic [SRC_W-1:0] BYPASS_MASK = 32'h0000_0007
) (
    input  logic [SRC_W-1:0]   irq_i,
    input  logic [SRC_W-1:0]   en_i,
    output logic [SRC_W-1:0]   pending_o,
    output logic [NUM_AGG-1:0] agg_o,
    output logic [SRC_W-1:0]   fwd_o
);
    logic [SRC_W-1:0] merge_pool;

    assign pending_o  = irq_i & en_i & WIRED_MASK;
    assign merge_pool = pending_o & ~BYPASS_MASK;

    for (genvar k = 0; k < NUM_AGG; k++) begin : g_agg
        assign agg_o[k] = |(merge_pool & AGG_MASK[k]);
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_fwd
        if (BYPASS_MASK[i] && WIRED_MASK[i]) begin : g_mux
            assign fwd_o[i] = pending_o[i];
        end else begin : g_off
            assign fwd_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_AGG = 2,
    parameter logic [NUM_AGG-1:0][NUM_SRC-1:0] AGG_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [NUM_SRC-1:0] WIRED_MASK   = 32'h0000_0FFF,
    parameter logic [NUM_SRC-1:0] BYPASS_MASK  = 32'h0000_0007,
    parameter bit                 WAKE_CAPABLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_write_i,
    input  logic [2:0]         req_addr_i,
    input  logic [NUM_SRC-1:0] req_wdata_i,
    output logic               rsp_valid_o,
    output logic [NUM_SRC-1:0] rsp_rdata_o,
    input  logic               suspend_i,
    input  logic               resume_i,
    input  logic [NUM_SRC-1:0] wake_active_i,
    output logic [NUM_AGG-1:0] agg_irq_o,
    output logic [NUM_SRC-1:0] fwd_irq_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pending;

    assign req_ready_o = 1'b1;

    irq_cascade_regs #(
        .WIRED_MASK  (WIRED_MASK),
        .BYPASS_MASK (BYPASS_MASK),
        .WAKE_CAPABLE(WAKE_CAPABLE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_write_i  (req_write_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .suspend_i    (suspend_i),
        .resume_i     (resume_i),
        .wake_active_i(wake_active_i),
        .pending_i    (pending),
        .en_o         (en_q),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_rdata_o  (rsp_rdata_o)
    );

    irq_cascade_route #(
        .NUM_AGG    (NUM_AGG),
        .AGG_MASK   (AGG_MASK),
        .WIRED_MASK (WIRED_MASK),
        .BYPASS_MASK(BYPASS_MASK)
    ) u_route (
        .irq_i    (irq_i),
        .en_i     (en_q),
        .pending_o(pending),
        .agg_o    (agg_irq_o),
        .fwd_o    (fwd_irq_o)
    );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_AGG = 2,
    parameter logic [NUM_AGG-1:0][NUM_SRC-1:0] AGG_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [NUM_SRC-1:0] WIRED_MASK   = 32'h0000_0FFF,
    parameter logic [NUM_SRC-1:0] BYPASS_MASK  = 32'h0000_0007,
    parameter bit                 WAKE_CAPABLE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_i,
    input logic               req_valid_i,
    input logic               req_ready_o,
    input logic               req_write_i,
    input logic [2:0]         req_addr_i,
    input logic               rsp_valid_o,
    input logic               suspend_i,
    input logic               resume_i,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_AGG-1:0] agg_irq_o,
    input logic [NUM_SRC-1:0] fwd_irq_o
);
    // R9: response one cycle after an accepted request
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> rsp_valid_o);
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);

    // R6: fast path only for active bypassed wired sources
    assert_fwd_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_irq_o & ~(irq_i & BYPASS_MASK & WIRED_MASK)) == '0);

    // R5: an aggregated output needs an active selected source
    for (genvar k = 0; k < NUM_AGG; k++) begin : g_chk
        assert_agg_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            agg_irq_o[k] |-> ((irq_i & en_q & AGG_MASK[k] & ~BYPASS_MASK & WIRED_MASK) != '0));
    end

    // R4: a write to the pending offset leaves the enable word alone
    assert_pending_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_addr_i != 3'd0 && !suspend_i && !resume_i)
        |=> $stable(en_q));

    // R7: after suspend the bypass set is enabled when wake-capable
    assert_suspend_keeps_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && WAKE_CAPABLE) |=> ((en_q & BYPASS_MASK & WIRED_MASK) == (BYPASS_MASK & WIRED_MASK)));
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .NUM_SRC     (NUM_SRC),
    .NUM_AGG     (NUM_AGG),
    .AGG_MASK    (AGG_MASK),
    .WIRED_MASK  (WIRED_MASK),
    .BYPASS_MASK (BYPASS_MASK),
    .WAKE_CAPABLE(WAKE_CAPABLE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .rsp_valid_o(rsp_valid_o),
    .suspend_i  (suspend_i),
    .resume_i   (resume_i),
    .en_q       (en_q),
    .agg_irq_o  (agg_irq_o),
    .fwd_irq_o  (fwd_irq_o)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        suspend = 1'b0;
    logic        resume = 1'b0;
    logic [31:0] wake_active = '0;
    logic [1:0]  agg;
    logic [31:0] fwd;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_cascade_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .suspend_i(suspend), .resume_i(resume), .wake_active_i(wake_active),
        .agg_irq_o(agg), .fwd_irq_o(fwd)
    );

    // enable written, source level, expected pending, aggregated, fast path
    localparam logic [31:0] V_EN  [0:6] = '{32'hFFF, 32'hFFF, 32'hFFF, 32'h0F7, 32'hFFFF_FFFF, 32'h106, 32'h000};
    localparam logic [31:0] V_IRQ [0:6] = '{32'h001, 32'h008, 32'h040, 32'h148, 32'hFFFF_F000, 32'h106, 32'hFFF};
    localparam logic [31:0] V_PND [0:6] = '{32'h001, 32'h008, 32'h040, 32'h040, 32'h000, 32'h106, 32'h000};
    localparam logic [31:0] V_AGG [0:6] = '{32'h0, 32'h1, 32'h2, 32'h2, 32'h0, 32'h2, 32'h0};
    localparam logic [31:0] V_FWD [0:6] = '{32'h001, 32'h000, 32'h000, 32'h000, 32'h000, 32'h006, 32'h000};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rsp_rdata; v = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(3'd0, d, v);
        check("R1 enable after reset", d, 32'h007);
        check("R9 response strobe", {31'b0, v}, 32'h1);
        bus_read(3'd4, d, v);
        check("R1 pending after reset", d, 32'h000);

        // table walk: R2 R3 R5 R6
        for (int n = 0; n < 7; n++) begin
            bus_write(3'd0, V_EN[n]);
            irq = V_IRQ[n];
            bus_read(3'd0, d, v);
            check("R2 enable readback", d, V_EN[n] & 32'hFFF);
            bus_read(3'd4, d, v);
            check("R3 pending word", d, V_PND[n]);
            check("R5 aggregated outputs", {30'b0, agg}, V_AGG[n]);
            check("R6 fast path outputs", fwd, V_FWD[n]);
        end

        // R4: ignored writes, unmapped reads
        bus_write(3'd0, 32'h0A5);
        bus_write(3'd4, 32'hFFF);
        bus_write(3'd3, 32'hFFF);
        bus_read(3'd0, d, v);
        check("R4 enable untouched by other offsets", d, 32'h0A5);
        bus_read(3'd2, d, v);
        check("R4 unmapped read zero", d, 32'h0);
        bus_read(3'd6, d, v);
        check("R4 unmapped read zero high", d, 32'h0);

        // R6: bypassed source never reaches aggregated outputs
        bus_write(3'd0, 32'hFFF);
        @(negedge clk);
        irq = 32'h007;
        @(negedge clk);
        check("R6 bypass leaves aggregate low", {30'b0, agg}, 32'h0);
        check("R6 bypass fast path", fwd, 32'h007);
        irq = '0;

        // R7: suspend with wake sources
        bus_write(3'd0, 32'h030);
        @(negedge clk);
        wake_active = 32'h8000_0800;
        suspend = 1'b1;
        @(negedge clk);
        suspend = 1'b0;
        bus_read(3'd0, d, v);
        check("R7 enable during suspend", d, 32'h837);

        // R8: resume restores saved word
        bus_write(3'd0, 32'h000);
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        bus_read(3'd0, d, v);
        check("R8 enable after resume", d, 32'h037);

        // R10: suspend and write collide
        bus_write(3'd0, 32'h010);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 32'h000;
        suspend = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; suspend = 1'b0;
        bus_read(3'd0, d, v);
        check("R10 suspend wins over write", d, 32'h817);
        @(negedge clk);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        bus_read(3'd0, d, v);
        check("R10 saved word from collision", d, 32'h017);

        finish_run();
    end
endmodule